// File: doc/BRIEF.md
# Command-Driven Converter Serial Port

This block is the host-facing serial slave of a data converter. A host selects it with an active-low chip select, clocks it with a serial clock, and exchanges bits on one data input and one data output. Every transaction opens with an 8-bit command word. The command either moves a 24-bit word into or out of one of eight configuration registers, or places the port in conversion readout mode.

In conversion readout mode a conversion timer runs from the master clock. One conversion period is the divisor held in register 0. The first period after the mode is entered is longer by seven master cycles. When a result is ready, the data output is pulled low. The host then gives eight clocks to acknowledge the flag and twenty-four more to shift the result out. A result that is not read in time is replaced by the next one. The serial clock, chip select and data input are resynchronised to the master clock, and edges on them are detected there, so the serial clock must run well below the master clock.

Top module: `adc_serial_port`

## Requirements
- R1: `sdo_oe` is low whenever `cs_n` is high and high whenever `cs_n` is low.
- R2: Serial clock edges that arrive while `cs_n` is high change no register and start no transaction.
- R3: The command word is 8 bits, sampled on rising serial clock edges, MSB first. Bit 7 set means read, bit 7 clear means write, bits 6:3 must be zero for a register access, and bits 2:0 give the register index. The code 8'hC0 enters conversion readout. Any other code takes 24 data clocks, writes nothing, and drives `sdo` low.
- R4: A write command takes the next 24 bits from `sdi`, MSB first, and stores them in the selected register at the 24th bit.
- R5: A read command presents the selected register on `sdo`, MSB first. Each bit changes on a falling serial clock edge, the first one on the falling edge that ends the command. Frames may follow one another with `cs_n` held low.
- R6: Raising `cs_n` during a frame drops it. A partly shifted write leaves the register unchanged, and the next frame starts with a new command.
- R7: In conversion readout, `sdo` is high while no result is pending and low once one is ready. Raising `cs_n` leaves the mode.
- R8: After the flag, 8 clocks clear it and the next 24 clocks carry the result, MSB first. Results are numbered 1, 2, 3 and so on from the start of the mode.
- R9: The first result is ready D+7 master cycles after the mode starts, and each later one D cycles after the one before. D is register 0, with values below 8 taken as 8. Register 0 resets to 2000 and the other registers reset to zero.
- R10: A result that is still unread when the next conversion completes is overwritten, so the host reads the newest result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock that times the conversions and samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |

## Verification
The hardest behaviour to reach is the overwrite of an unread result. It depends on master-clock timing that cannot be seen from the serial side. The stimulus takes a fixed reference cycle at the rising edge that completes the conversion command. It then samples `sdo` a few cycles either side of D+7 and 2D+7, which exposes both the first-conversion latency and the steady period. It then idles across two more conversion periods before reading, so that the fourth result, and not the third, must come out.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_WR,
      PH_RD,
      PH_SKIP,
      PH_CWAIT,
      PH_CDATA
   } phase_t;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic cs_q,
   output logic sdi_q,
   output logic rise,
   output logic fall
);

   logic sclk_q;
   logic sclk_d;

   generate
      if (STAGES == 0) begin : g_bypass
         assign cs_q   = cs_n;
         assign sclk_q = sclk;
         assign sdi_q  = sdi;
      end else begin : g_sync
         logic [STAGES-1:0] cs_r;
         logic [STAGES-1:0] sclk_r;
         logic [STAGES-1:0] sdi_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_r   <= '1;
               sclk_r <= '0;
               sdi_r  <= '0;
            end else begin
               cs_r[0]   <= cs_n;
               sclk_r[0] <= sclk;
               sdi_r[0]  <= sdi;
               for (int k = 1; k < STAGES; k++) begin
                  cs_r[k]   <= cs_r[k-1];
                  sclk_r[k] <= sclk_r[k-1];
                  sdi_r[k]  <= sdi_r[k-1];
               end
            end
         end
         assign cs_q   = cs_r[STAGES-1];
         assign sclk_q = sclk_r[STAGES-1];
         assign sdi_q  = sdi_r[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_q;
   end

   assign rise = sclk_q & ~sclk_d & ~cs_q;
   assign fall = ~sclk_q & sclk_d & ~cs_q;

endmodule

// File: rtl/adc_sp_conv.sv
module adc_sp_conv #(
   parameter int DIV_W       = 24,
   parameter int DATA_W      = 24,
   parameter int MIN_DIV     = 8,
   parameter int FIRST_EXTRA = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [DIV_W-1:0]  div_raw,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0]  div_eff;
   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] seq;

   assign div_eff = (div_raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_raw;
   assign done    = run & ~start & (cnt == '0);
   assign result  = seq + DATA_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         seq <= '0;
      end else if (start) begin
         cnt <= {1'b0, div_eff} + CW'(FIRST_EXTRA - 1);
         seq <= '0;
      end else if (run) begin
         if (cnt == '0) begin
            cnt <= {1'b0, div_eff} - CW'(1);
            seq <= seq + DATA_W'(1);
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   // checker: cycles between conversion events, counted independently
   logic [CW-1:0]    gap;
   logic             first_q;
   logic             chk_ok;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap     <= '0;
         first_q <= 1'b0;
         chk_ok  <= 1'b0;
         div_q   <= '0;
      end else begin
         div_q <= div_eff;
         if (start) begin
            gap     <= '0;
            first_q <= 1'b1;
            chk_ok  <= 1'b1;
         end else if (done) begin
            gap     <= '0;
            first_q <= 1'b0;
         end else begin
            gap <= gap + CW'(1);
         end
         if (!start && (div_eff != div_q)) chk_ok <= 1'b0;
      end
   end

   assert_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && chk_ok) |-> (gap == (first_q ? ({1'b0, div_eff} + CW'(FIRST_EXTRA - 1))
                                            : ({1'b0, div_eff} - CW'(1)))));

endmodule

// File: rtl/adc_sp_frame.sv
module adc_sp_frame
   import adc_sp_pkg::*;
#(
   parameter int              DATA_W    = 24,
   parameter int              CMD_W     = 8,
   parameter int              NUM_REGS  = 8,
   parameter int              DIV_RST   = 2000,
   parameter logic [CMD_W-1:0] CONV_CODE = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_q,
   input  logic              sdi_q,
   input  logic              rise,
   input  logic              fall,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   output logic              sdo,
   output logic              conv_start,
   output logic              conv_run,
   output logic [DATA_W-1:0] div_val
);

   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int CNT_W = $clog2(DATA_W);

   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic [CMD_W-1:0]  cmd_sh;
   logic [DATA_W-1:0] sh;
   logic [IDX_W-1:0]  idx;
   logic              sdo_q;
   logic              ready;
   logic [DATA_W-1:0] result_q;
   logic [DATA_W-1:0] regs [NUM_REGS];

   logic [CMD_W-1:0]  cmd_full;
   logic [IDX_W-1:0]  cmd_idx;
   logic              last_cmd;
   logic              last_data;
   logic              is_conv;
   logic              is_reg;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;

   assign cmd_full   = {cmd_sh[CMD_W-2:0], sdi_q};
   assign cmd_idx    = cmd_full[IDX_W-1:0];
   assign last_cmd   = (cnt == CNT_W'(CMD_W - 1));
   assign last_data  = (cnt == CNT_W'(DATA_W - 1));
   assign is_conv    = (cmd_full == CONV_CODE);
   assign is_reg     = (cmd_full[CMD_W-2:IDX_W] == '0);
   assign conv_start = rise && (phase == PH_CMD) && last_cmd && is_conv;
   assign wr_en      = rise && (phase == PH_WR) && last_data;
   assign wr_data    = {sh[DATA_W-2:0], sdi_q};
   assign div_val    = regs[0];
   assign sdo        = (phase == PH_CWAIT) ? ~ready : sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
         if (!rst_n)
            regs[i] <= (i == 0) ? DATA_W'(DIV_RST) : '0;
         else if (wr_en && (idx == IDX_W'(i)))
            regs[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         cnt      <= '0;
         cmd_sh   <= '0;
         sh       <= '0;
         idx      <= '0;
         sdo_q    <= 1'b0;
         ready    <= 1'b0;
         result_q <= '0;
         conv_run <= 1'b0;
      end else begin
         if (conv_done) begin
            result_q <= conv_result;
            ready    <= 1'b1;
         end
         if (cs_q) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            sdo_q    <= 1'b0;
            ready    <= 1'b0;
            conv_run <= 1'b0;
         end else begin
            unique case (phase)
               PH_CMD: begin
                  if (fall) sdo_q <= 1'b0;
                  if (rise) begin
                     cmd_sh <= cmd_full;
                     if (last_cmd) begin
                        cnt <= '0;
                        if (is_conv) begin
                           phase    <= PH_CWAIT;
                           conv_run <= 1'b1;
                           ready    <= 1'b0;
                        end else if (is_reg && cmd_full[CMD_W-1]) begin
                           phase <= PH_RD;
                           sh    <= regs[cmd_idx];
                        end else if (is_reg) begin
                           phase <= PH_WR;
                           idx   <= cmd_idx;
                        end else begin
                           phase <= PH_SKIP;
                        end
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
               end
               PH_WR, PH_SKIP: begin
                  if (fall) sdo_q <= 1'b0;
                  if (rise) begin
                     sh <= wr_data;
                     if (last_data) begin
                        cnt   <= '0;
                        phase <= PH_CMD;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
               end
               PH_RD, PH_CDATA: begin
                  if (fall) begin
                     sdo_q <= sh[DATA_W-1];
                     sh    <= {sh[DATA_W-2:0], 1'b0};
                  end
                  if (rise) begin
                     if (last_data) begin
                        cnt   <= '0;
                        phase <= (phase == PH_CDATA) ? PH_CWAIT : PH_CMD;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
               end
               PH_CWAIT: begin
                  if (rise && ready) begin
                     if (last_cmd) begin
                        cnt   <= '0;
                        phase <= PH_CDATA;
                        sh    <= result_q;
                        ready <= conv_done;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
               end
               default: phase <= PH_CMD;
            endcase
         end
      end
   end

   assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_q) |-> (phase == PH_CMD && cnt == '0));

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < DATA_W);

   assert_flag_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CDATA && $past(phase) == PH_CWAIT) |-> $past(ready));

   assert_no_write_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |-> !wr_en);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
   parameter int DATA_W      = 24,
   parameter int CMD_W       = 8,
   parameter int NUM_REGS    = 8,
   parameter int DIV_RST     = 2000,
   parameter int MIN_DIV     = 8,
   parameter int FIRST_EXTRA = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);

   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (MIN_DIV < 8) begin : g_bad_min_div
         $error("MIN_DIV must be at least 8");
      end
      if ((1 << IDX_W) != NUM_REGS) begin : g_bad_regs
         $error("NUM_REGS must be a power of two");
      end
      if (CMD_W < IDX_W + 2) begin : g_bad_cmd
         $error("CMD_W too narrow for the register index");
      end
      if (DATA_W <= CMD_W) begin : g_bad_data
         $error("DATA_W must exceed CMD_W");
      end
      if (DIV_RST < MIN_DIV || FIRST_EXTRA < 1) begin : g_bad_timing
         $error("conversion timing parameters out of range");
      end
   endgenerate

   logic              cs_q;
   logic              sdi_q;
   logic              rise;
   logic              fall;
   logic              conv_start;
   logic              conv_run;
   logic              conv_done;
   logic [DATA_W-1:0] conv_result;
   logic [DATA_W-1:0] div_val;

   adc_sp_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .sclk  (sclk),
      .sdi   (sdi),
      .cs_q  (cs_q),
      .sdi_q (sdi_q),
      .rise  (rise),
      .fall  (fall)
   );

   adc_sp_conv #(
      .DIV_W       (DATA_W),
      .DATA_W      (DATA_W),
      .MIN_DIV     (MIN_DIV),
      .FIRST_EXTRA (FIRST_EXTRA)
   ) u_conv (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (conv_start),
      .run     (conv_run),
      .div_raw (div_val),
      .done    (conv_done),
      .result  (conv_result)
   );

   adc_sp_frame #(
      .DATA_W   (DATA_W),
      .CMD_W    (CMD_W),
      .NUM_REGS (NUM_REGS),
      .DIV_RST  (DIV_RST)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_q        (cs_q),
      .sdi_q       (sdi_q),
      .rise        (rise),
      .fall        (fall),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .sdo         (sdo),
      .conv_start  (conv_start),
      .conv_run    (conv_run),
      .div_val     (div_val)
   );

   assign sdo_oe = ~cs_n;

endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;

   localparam int DW  = 24;
   localparam int DIV = 2000;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n  = 1'b1;
   logic sclk  = 1'b0;
   logic sdi   = 1'b0;
   logic sdo;
   logic sdo_oe;

   int cyc    = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] act_q[$];
   string         tag_q[$];

   adc_serial_port u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .sclk   (sclk),
      .sdi    (sdi),
      .sdo    (sdo),
      .sdo_oe (sdo_oe)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic bit_io(input logic v, output logic so);
      sdi  = v;
      so   = sdo;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
   endtask

   task automatic xfer(input logic [7:0] cmd, input logic [DW-1:0] din, input bit chk,
                       input logic [DW-1:0] expv, input string tag);
      logic          so;
      logic [DW-1:0] cap = '0;
      for (int i = 7; i >= 0; i--) bit_io(cmd[i], so);
      for (int i = DW - 1; i >= 0; i--) begin
         bit_io(din[i], so);
         cap = {cap[DW-2:0], so};
      end
      if (chk) begin
         exp_q.push_back(expv);
         tag_q.push_back(tag);
         act_q.push_back(cap);
      end
   endtask

   task automatic sel;
      cs_n = 1'b0;
      tick(4);
   endtask

   task automatic desel;
      tick(4);
      cs_n = 1'b1;
      tick(8);
   endtask

   task automatic wr(input logic [2:0] idx, input logic [DW-1:0] d);
      sel();
      xfer({5'b00000, idx}, d, 1'b0, '0, "");
      desel();
   endtask

   task automatic rd(input logic [2:0] idx, input logic [DW-1:0] e, input string tag);
      sel();
      xfer({5'b10000, idx}, 24'h5A5A5A, 1'b1, e, tag);
      desel();
   endtask

   task automatic conv_read(input logic [DW-1:0] e, input string tag);
      logic          so;
      logic [DW-1:0] cap = '0;
      int            n = 0;
      while (sdo !== 1'b0 && n < 20000) begin
         tick(1);
         n++;
      end
      if (n >= 20000) check(1'b0, tag, 32'(sdo), 0);
      for (int i = 0; i < 8; i++) bit_io(1'b0, so);
      for (int i = 0; i < DW; i++) begin
         bit_io(1'b0, so);
         cap = {cap[DW-2:0], so};
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      act_q.push_back(cap);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         logic [DW-1:0] a;
         logic [DW-1:0] e;
         string         t;
         wait (act_q.size() > 0);
         a = act_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(a == e, t, 32'(a), 32'(e));
      end
   end

   initial begin
      tick(150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic so;
      int   t0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      check(sdo_oe == 1'b0, "R1 deselected oe", 32'(sdo_oe), 0);
      rd(3'd0, 24'(DIV), "R9 reset divisor value");
      rd(3'd3, 24'h000000, "R9 reset register zero");

      sel();
      check(sdo_oe == 1'b1, "R1 selected oe", 32'(sdo_oe), 1);
      desel();

      // R4 / R5 basic write and read
      wr(3'd2, 24'hA5C3F0);
      rd(3'd2, 24'hA5C3F0, "R4 write reg2");
      wr(3'd7, 24'h123456);
      rd(3'd7, 24'h123456, "R4 write reg7");
      rd(3'd2, 24'hA5C3F0, "R5 reg2 kept");

      // R5 back-to-back frames with chip select held low
      sel();
      xfer(8'h05, 24'h800001, 1'b0, '0, "");
      xfer(8'h85, 24'h000000, 1'b1, 24'h800001, "R5 three-wire read reg5");
      xfer(8'h87, 24'hFFFFFF, 1'b1, 24'h123456, "R5 three-wire read reg7");
      desel();

      // R2 clocks while deselected
      xfer(8'h02, 24'h000000, 1'b0, '0, "");
      tick(8);
      rd(3'd2, 24'hA5C3F0, "R2 deselected clocks ignored");

      // R6 abort of a partial write
      sel();
      for (int i = 7; i >= 0; i--) bit_io(i == 1, so);
      for (int i = 0; i < 10; i++) bit_io(1'b1, so);
      desel();
      rd(3'd2, 24'hA5C3F0, "R6 partial write dropped");
      rd(3'd7, 24'h123456, "R6 next frame decoded");

      // R3 unknown codes
      sel();
      xfer(8'h4A, 24'hFFFFFF, 1'b1, 24'h000000, "R3 unknown code sdo low");
      xfer(8'h3A, 24'hFFFFFF, 1'b0, '0, "");
      xfer(8'h82, 24'h000000, 1'b1, 24'hA5C3F0, "R3 nonzero middle bits no write");
      desel();

      // R7..R10 conversion readout
      sel();
      for (int i = 7; i >= 0; i--) bit_io(i >= 6, so);
      t0 = cyc;
      wait_until(t0 + 1996);
      check(sdo == 1'b1, "R9 first conversion not early", 32'(sdo), 1);
      check(sdo == 1'b1, "R7 flag high while pending", 32'(sdo), 1);
      wait_until(t0 + 2006);
      check(sdo == 1'b0, "R7 flag low when ready", 32'(sdo), 0);
      conv_read(24'd1, "R8 first result");
      wait_until(t0 + 3996);
      check(sdo == 1'b1, "R9 later period not early", 32'(sdo), 1);
      wait_until(t0 + 4006);
      check(sdo == 1'b0, "R9 later period on time", 32'(sdo), 0);
      conv_read(24'd2, "R8 second result");
      wait_until(t0 + 9300);
      conv_read(24'd4, "R10 newest result after overwrite");
      desel();
      check(sdo_oe == 1'b0, "R1 oe after conversion", 32'(sdo_oe), 0);
      rd(3'd2, 24'hA5C3F0, "R7 chip select leaves conversion mode");

      tick(4);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule